// File: doc/BRIEF.md
# PWM Compare Event Trigger

This block sits behind the digital comparators of one PWM channel and turns two independent compare events into the four actions the rest of the channel consumes. The four actions are an immediate force, an interrupt request, an ADC start-of-conversion and a time-base counter sync. For each event, software picks one of two sources: the raw comparator event, or a version of it that has already been through a blanking filter outside this block. A one-cycle software force request is merged in by OR. The result then either passes straight through with no clock in the way, or is resynchronized to the time-base clock through a two-stage flop chain.

Each event owns a sticky flag. The flag is set whenever the selected event is active and holds until software writes a clear. The interrupt request is that flag, gated by a per-event enable. The start-of-conversion and counter-sync outputs follow the live event, and each has its own enable. A small register port holds the configuration bits, the force and clear strobes, and a read-only view of the flags. Reads are combinational on the same address bus used for writes.

Top module: `cmp_evt_trigger`

## Requirements
- R1: With its source-select bit at 1, an event follows `filt_evt[i]`. With the bit at 0, it follows `raw_evt[i]`. The unselected input has no effect on any output.
- R2: Writing 1 to bit i of the force register (address 1) makes event i active for exactly one clock cycle: the cycle after the write edge. This happens even while the selected input is low.
- R3: With sync-select at 0, `evt_force[i]` follows the combined event (source OR force) combinationally, within the same cycle.
- R4: With sync-select at 1, `evt_force[i]` follows the combined event delayed by two time-base clock edges. This holds for both the raw and the filtered source.
- R5: While `evt_force[i]` is high at a clock edge, flag i is set at that edge. The flag then stays set until bit i of the clear register (address 2) is written with 1. Flag i reads as bit i of address 3.
- R6: `evt_int[i]` is high exactly when flag i is set and the interrupt-enable bit of event i is 1.
- R7: `evt_soc[i]` equals `evt_force[i]` when the SOC-enable bit of event i is 1, and is 0 otherwise.
- R8: `evt_sync[i]` equals `evt_force[i]` when the sync-enable bit of event i is 1, and is 0otherwise.
- R9: The control register is at address 0. Event i occupies bits 5i to 5i+4, with the following offsets: +0 source select, +1 sync select, +2 SOC enable, +3 sync enable, +4 interrupt enable. It reads back what was written. The force and clear registers always read as zero.
- R10: If an active event and a clear of the same flag meet at one clock edge, the flag stays set.
- R11: After reset, the control register and all flags read zero, and all outputs are low while the inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for writes and reads |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| raw_evt | input | NUM_EVT | Raw compare events, one per event |
| filt_evt | input | NUM_EVT | Blanking-filtered compare events |
| evt_force | output | NUM_EVT | Event after source, force and sync selection |
| evt_int | output | NUM_EVT | Interrupt request: flag AND interrupt enable |
| evt_soc | output | NUM_EVT | ADC start-of-conversion pulse |
| evt_sync | output | NUM_EVT | Time-base counter sync |

## Verification
The bench builds the block with its defaults: two events, a 16-bit data word and a two-stage synchronizer. With two events, the field packing of the control word can be checked, and so can the absence of crosstalk between events, with event 1 driven while event 0 is watched. With exactly two synchronizer stages, the bench can predict edge by edge when a raw level or a one-cycle force pulse leaves the synchronized path. This also switches on the in-module check that compares the synchronizer output with its input from two edges earlier.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

    parameter int REG_ADDR_W = 2;
    parameter int CFG_W      = 5;

    typedef enum logic [REG_ADDR_W-1:0] {
        ADR_CTRL  = 2'd0,
        ADR_FORCE = 2'd1,
        ADR_CLEAR = 2'd2,
        ADR_FLAG  = 2'd3
    } reg_addr_e;

    // Per-event configuration; src_sel sits at the least significant bit.
    typedef struct packed {
        logic int_en;
        logic sync_en;
        logic soc_en;
        logic sync_sel;
        logic src_sel;
    } evt_cfg_t;

    // Per-event actions.
    typedef struct packed {
        logic trig;
        logic intr;
        logic soc;
        logic sync;
    } evt_out_t;

    function automatic logic pick_src(input evt_cfg_t c, input logic raw, input logic filt);
        return c.src_sel ? filt : raw;
    endfunction

endpackage

// File: rtl/cmp_evt_regs.sv
module cmp_evt_regs
    import cmp_evt_pkg::*;
#(
    parameter int NUM_EVT = 2,
    parameter int DATA_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [REG_ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [NUM_EVT-1:0]     flags_in,
    output logic [DATA_W-1:0]      rdata,
    output evt_cfg_t [NUM_EVT-1:0] cfg_o,
    output logic [NUM_EVT-1:0]     frc_pulse,
    output logic [NUM_EVT-1:0]     clr_strobe
);

    localparam int CTRL_W = NUM_EVT * CFG_W;

    logic [CTRL_W-1:0]  ctrl_q;
    logic [NUM_EVT-1:0] frc_q;
    logic               wr_ctrl, wr_force, wr_clear;
    logic               unused_wdata;

    assign unused_wdata = ^wdata;

    assign wr_ctrl  = wr_en && (addr == ADR_CTRL);
    assign wr_force = wr_en && (addr == ADR_FORCE);
    assign wr_clear = wr_en && (addr == ADR_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            frc_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wdata[CTRL_W-1:0];
            end
            frc_q <= wr_force ? wdata[NUM_EVT-1:0] : '0;
        end
    end

    assign frc_pulse  = frc_q;
    assign clr_strobe = wr_clear ? wdata[NUM_EVT-1:0] : '0;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_cfg
        assign cfg_o[i] = evt_cfg_t'(ctrl_q[i*CFG_W +: CFG_W]);
    end

    always_comb begin
        case (addr)
            ADR_CTRL: rdata = DATA_W'(ctrl_q);
            ADR_FLAG: rdata = DATA_W'(flags_in);
            default:  rdata = '0;
        endcase
    end

    // R9
    strobe_regs_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == ADR_FORCE || addr == ADR_CLEAR) |-> (rdata == '0));

    // R2
    force_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ((frc_q != '0) && !wr_force) |=> (frc_q == '0));

endmodule

// File: rtl/cmp_evt_sync.sv
module cmp_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);

    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-2:0], d_in};
        end
    end

    assign q_out = sh[STAGES-1];

    if (STAGES == 2) begin : g_lat_chk
        logic [1:0] age;
        always_ff @(posedge clk) begin
            if (rst) begin
                age <= '0;
            end else if (age != 2'd2) begin
                age <= age + 2'd1;
            end
        end

        // R4
        sync_latency_chk: assert property (@(posedge clk) disable iff (rst)
            (age == 2'd2) |-> (q_out == $past(d_in, 2)));
    end

endmodule

// File: rtl/cmp_evt_path.sv
module cmp_evt_path
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     raw_in,
    input  logic     filt_in,
    input  logic     frc_in,
    input  logic     clr_in,
    input  evt_cfg_t cfg_in,
    output evt_out_t out_o,
    output logic     flag_o
);

    logic combined, synced, evt, flag_q;

    assign combined = pick_src(cfg_in, raw_in, filt_in) | frc_in;

    cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (combined),
        .q_out (synced)
    );

    assign evt = cfg_in.sync_sel ? synced : combined;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (evt) begin
            flag_q <= 1'b1;
        end else if (clr_in) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        out_o.trig = evt;
        out_o.intr = flag_q & cfg_in.int_en;
        out_o.soc  = evt & cfg_in.soc_en;
        out_o.sync = evt & cfg_in.sync_en;
    end

    assign flag_o = flag_q;

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_in) |=> flag_q);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (out_o.trig && clr_in) |=> flag_q);

    // R6
    int_after_event_chk: assert property (@(posedge clk) disable iff (rst)
        (out_o.trig && cfg_in.int_en) |=> (out_o.intr || !$stable(cfg_in)));

    // R7
    soc_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.soc |-> out_o.trig);

    // R8
    sync_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        out_o.sync |-> out_o.trig);

endmodule

// File: rtl/cmp_evt_trigger.sv
module cmp_evt_trigger
    import cmp_evt_pkg::*;
#(
    parameter int NUM_EVT     = 2,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_EVT-1:0]    raw_evt,
    input  logic [NUM_EVT-1:0]    filt_evt,
    output logic [NUM_EVT-1:0]    evt_force,
    output logic [NUM_EVT-1:0]    evt_int,
    output logic [NUM_EVT-1:0]    evt_soc,
    output logic [NUM_EVT-1:0]    evt_sync
);

    evt_cfg_t [NUM_EVT-1:0] cfg;
    logic [NUM_EVT-1:0]     frc_pulse;
    logic [NUM_EVT-1:0]     clr_strobe;
    logic [NUM_EVT-1:0]     flags;

    cmp_evt_regs #(.NUM_EVT(NUM_EVT), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .flags_in   (flags),
        .rdata      (reg_rdata),
        .cfg_o      (cfg),
        .frc_pulse  (frc_pulse),
        .clr_strobe (clr_strobe)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        evt_out_t o;

        cmp_evt_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
            .clk     (clk),
            .rst     (rst),
            .raw_in  (raw_evt[i]),
            .filt_in (filt_evt[i]),
            .frc_in  (frc_pulse[i]),
            .clr_in  (clr_strobe[i]),
            .cfg_in  (cfg[i]),
            .out_o   (o),
            .flag_o  (flags[i])
        );

        assign evt_force[i] = o.trig;
        assign evt_int[i]   = o.intr;
        assign evt_soc[i]   = o.soc;
        assign evt_sync[i]  = o.sync;
    end

    // R11
    quiet_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (evt_int == '0));

endmodule

// File: tb/cmp_evt_trigger_tb.sv
`timescale 1ns/1ps
module cmp_evt_trigger_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic [1:0]  raw_evt, filt_evt;
    logic [1:0]  evt_force, evt_int, evt_soc, evt_sync;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    cmp_evt_trigger u_dut (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .raw_evt   (raw_evt),
        .filt_evt  (filt_evt),
        .evt_force (evt_force),
        .evt_int   (evt_int),
        .evt_soc   (evt_soc),
        .evt_sync  (evt_sync)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Field of one event: {int_en, sync_en, soc_en, sync_sel, src_sel}
    function automatic logic [4:0] fld(input logic src, input logic ssel, input logic soc,
                                       input logic syn, input logic ien);
        return {ien, syn, soc, ssel, src};
    endfunction

    task automatic clear_all();
        raw_evt = '0; filt_evt = '0;
        wr(2'd0, 16'h0000);
        repeat (3) @(negedge clk);
        wr(2'd2, 16'h0003);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        #1;
        check("R11 force", {14'd0, evt_force}, 16'h0);
        check("R11 int", {14'd0, evt_int}, 16'h0);
        check("R11 soc/sync", {12'd0, evt_soc, evt_sync}, 16'h0);
        rd(2'd0, v); check("R11 ctrl", v, 16'h0);
        rd(2'd3, v); check("R11 flags", v, 16'h0);
    endtask

    task automatic t_source();
        logic [15:0] v;
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,0,1,1,0)});
        rd(2'd0, v); check("R9 ctrl readback", v, {6'd0, fld(0,0,0,0,0), fld(0,0,1,1,0)});
        raw_evt = 2'b01; #1;
        check("R1 raw selected", {14'd0, evt_force}, 16'h1);
        check("R3 async soc", {14'd0, evt_soc}, 16'h1);
        check("R8 sync enabled", {14'd0, evt_sync}, 16'h1);
        raw_evt = 2'b00; filt_evt = 2'b01; #1;
        check("R1 filtered ignored", {14'd0, evt_force}, 16'h0);
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(1,0,1,1,0)});
        check("R1 filtered selected", {14'd0, evt_force}, 16'h1);
        filt_evt = 2'b00; raw_evt = 2'b01; #1;
        check("R1 raw ignored", {14'd0, evt_force}, 16'h0);
        clear_all();
    endtask

    task automatic t_sync();
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,1,1,0,0)});
        @(negedge clk); raw_evt = 2'b01; #1;
        check("R4 raw edge0", {14'd0, evt_force}, 16'h0);
        @(negedge clk); check("R4 raw edge1", {14'd0, evt_force}, 16'h0);
        @(negedge clk); check("R4 raw edge2", {14'd0, evt_force}, 16'h1);
        check("R7 soc in sync mode", {14'd0, evt_soc}, 16'h1);
        raw_evt = 2'b00;
        @(negedge clk); check("R4 raw fall1", {14'd0, evt_force}, 16'h1);
        @(negedge clk); check("R4 raw fall2", {14'd0, evt_force}, 16'h0);
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(1,1,0,0,0)});
        @(negedge clk); filt_evt = 2'b01;
        @(negedge clk); check("R4 filt edge1", {14'd0, evt_force}, 16'h0);
        @(negedge clk); check("R4 filt edge2", {14'd0, evt_force}, 16'h1);
        clear_all();
    endtask

    task automatic t_force();
        logic [15:0] v;
        wr(2'd0, {6'd0, fld(0,1,0,0,0), fld(0,0,1,0,0)});
        wr(2'd1, 16'h0001);
        check("R2 force async", {14'd0, evt_force}, 16'h1);
        check("R7 force soc", {14'd0, evt_soc}, 16'h1);
        rd(2'd1, v); check("R9 force reads zero", v, 16'h0);
        rd(2'd2, v); check("R9 clear reads zero", v, 16'h0);
        @(negedge clk); check("R2 force one cycle", {14'd0, evt_force}, 16'h0);
        wr(2'd1, 16'h0002);
        check("R2 sync force c0", {14'd0, evt_force}, 16'h0);
        @(negedge clk); check("R2 sync force c1", {14'd0, evt_force}, 16'h0);
        @(negedge clk); check("R2 sync force c2", {14'd0, evt_force}, 16'h2);
        @(negedge clk); check("R2 sync force c3", {14'd0, evt_force}, 16'h0);
        rd(2'd3, v); check("R5 forced flags", v, 16'h3);
        clear_all();
    endtask

    task automatic t_flag();
        logic [15:0] v;
        rd(2'd3, v); check("R5 flags cleared", v, 16'h0);
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,0,0,0,1)});
        @(negedge clk); raw_evt = 2'b01;
        @(negedge clk); raw_evt = 2'b00; #1;
        check("R6 int on flag", {14'd0, evt_int}, 16'h1);
        repeat (3) @(negedge clk);
        rd(2'd3, v); check("R5 flag sticky", v, 16'h1);
        raw_evt = 2'b01;
        wr(2'd2, 16'h0001);
        rd(2'd3, v); check("R10 set wins", v, 16'h1);
        raw_evt = 2'b00;
        wr(2'd2, 16'h0001);
        rd(2'd3, v); check("R5 cleared", v, 16'h0);
        check("R6 int drops", {14'd0, evt_int}, 16'h0);
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,0,0,0,0)});
        @(negedge clk); raw_evt = 2'b01;
        @(negedge clk); raw_evt = 2'b00; #1;
        rd(2'd3, v); check("R5 flag without int_en", v, 16'h1);
        check("R6 int gated", {14'd0, evt_int}, 16'h0);
        clear_all();
    endtask

    task automatic t_gate();
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,0,1,0,0)});
        raw_evt = 2'b01; #1;
        check("R7 soc on", {14'd0, evt_soc}, 16'h1);
        check("R8 sync off", {14'd0, evt_sync}, 16'h0);
        wr(2'd0, {6'd0, fld(0,0,0,0,0), fld(0,0,0,1,0)});
        check("R7 soc off", {14'd0, evt_soc}, 16'h0);
        check("R8 sync on", {14'd0, evt_sync}, 16'h1);
        raw_evt = 2'b00;
        wr(2'd0, {6'd0, fld(1,0,1,0,1), fld(0,0,0,0,0)});
        filt_evt = 2'b10; #1;
        check("R1 event1 filtered", {14'd0, evt_force}, 16'h2);
        check("R7 event1 soc", {14'd0, evt_soc}, 16'h2);
        @(negedge clk);
        check("R6 event1 int only", {14'd0, evt_int}, 16'h2);
        clear_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        raw_evt = '0; filt_evt = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_source();
        t_sync();
        t_force();
        t_flag();
        t_gate();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule